// File: doc/BRIEF.md
# Three-wire serial word-memory slave

This block is the slave end of a three-wire clocked serial memory with a chip select, a serial clock, a data input and a data output. It holds 512 words of 16 bits in an internal register file. It decodes five kinds of frame: read, single-word write, page write, write-enable and write-disable. A frame is an 8-bit op-code, an 8-bit address byte and, for writes, 16-bit data words, all sent most significant bit first. All pins are sampled by a free-running system clock `clk`. Serial clock edges are found by comparing each sample with the one before, so the serial clock must run well below `clk`.

A write is self-timed. When chip select rises at the end of a complete write frame, the block first erases each target word to all ones and then programs it. During that cycle the `ready` output is low for a parameterised number of system clocks, and no frame is accepted. A hardware protect input, `wp_rst`, and a write-enable latch both gate every write.

The level of the serial clock at the falling edge of chip select selects the mode. A high clock starts an instruction frame. A low clock starts a status readout, in which the data output shows the ready level.

Top module: `eep_slave`

## Requirements
- R1: After reset, `ready` is high, `sdo_oe` is low and the write-enable latch is clear.
- R2: A READ frame is op-code 1000_000A followed by an 8-bit address. After the last address bit, the addressed word appears on `sdo` MSB first. Each bit is updated after a falling edge of `sck`, and `sdo_oe` stays high while data is being returned.
- R3: Op-code 1001_1000 sets the write-enable latch and op-code 1001_0000 clears it. A WRITE frame (op-code 1010_000A, address byte, one 16-bit word) sent while the latch is clear changes no word and starts no write cycle.
- R4: If `wp_rst` is high at the chip-select rise that ends a write frame, no word changes and `ready` stays high.
- R5: A committed write drives `ready` low for exactly BUSY_CYCLES `clk` cycles, starting with the first `clk` edge that sees chip select high. When `ready` returns high, the target words hold the new data. At all other times `ready` is high.
- R6: A frame whose chip select falls during a write cycle is ignored entirely, including WREN and WRDS, and `sdo_oe` stays low for it.
- R7: If chip select falls while `sck` is low, the block enters status mode: `sdo_oe` is high and `sdo` equals the `ready` level. Rising `sck` edges with `sdi` low keep this mode. It ends on a rising `sck` edge with `sdi` high, or when chip select rises.
- R8: PAGE WRITE (op-code 1011_000A) accepts successive 16-bit words while chip select stays low. The low 3 address bits advance after each word and wrap within the 8-word page. All received words are written in one write cycle.
- R9: If chip select rises before a complete data word has been received, nothing is written and `ready` stays high.
- R10: While `sck` keeps toggling in a READ frame, the following words stream out at ascending addresses, and address 511 is followed by address 0.
- R11: Op-code bit 0 (A) is address bit 8, which selects the upper 256 words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in, sampled on rising `sck` |
| wp_rst | input | 1 | Hardware write protect, high blocks writes |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | High when `sdo` is actively driven |
| ready | output | 1 | Low during a self-timed write cycle |

## Verification
The assertions assume that `cs_n` never changes in the same `clk` cycle as an `sck` edge. They also assume that each `sck` level lasts several `clk` periods, so every edge appears in exactly one sample. The stimulus holds each serial clock phase for four system clocks. It changes chip select only in the middle of a phase, with `sck` high for frames and low for status probes. It changes `wp_rst` only while chip select is high and before the frame that it is meant to gate.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam int WORD_W     = 16;
    localparam int ADDR_W     = 9;
    localparam int SLOT_W     = 3;
    localparam int PAGE_WORDS = 1 << SLOT_W;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_W     = ADDR_W - SLOT_W;
    localparam int BYTE_W     = 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [2:0] {
        F_IDLE, F_STAT, F_OPC, F_ADDR, F_DATA, F_RDOUT, F_SKIP
    } fstate_e;

    typedef enum logic [2:0] {
        K_NONE, K_READ, K_WRITE, K_PAGE, K_WREN, K_WRDS
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  hi;
    } cmd_t;

    function automatic cmd_t decode_op(input logic [BYTE_W-1:0] op);
        cmd_t c;
        c.hi   = op[0];
        c.kind = K_NONE;
        case (op[7:1])
            7'b1000_000: c.kind = K_READ;
            7'b1010_000: c.kind = K_WRITE;
            7'b1011_000: c.kind = K_PAGE;
            7'b1001_100: if (!op[0]) c.kind = K_WREN;
            7'b1001_000: if (!op[0]) c.kind = K_WRDS;
            default:     c.kind = K_NONE;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/eep_frame.sv
module eep_frame
    import eep_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cs_n,
    input  logic                              sck,
    input  logic                              sdi,
    input  logic                              wp_rst,
    input  logic                              busy,
    input  logic [WORD_W-1:0]                 rd_data,
    output logic [ADDR_W-1:0]                 rd_addr,
    output logic                              sdo,
    output logic                              sdo_oe,
    output logic                              wr_go,
    output logic [PAGE_W-1:0]                 wr_page,
    output logic [PAGE_WORDS-1:0]             wr_mask,
    output logic [PAGE_WORDS-1:0][WORD_W-1:0] wr_words
);
    localparam int CNT_W  = $clog2(WORD_W) + 1;
    localparam int RCNT_W = $clog2(WORD_W);

    fstate_e                         state;
    kind_e                           kind;
    logic                            hi;
    logic [CNT_W-1:0]                cnt;
    word_t                           sh;
    addr_t                           addr;
    logic                            wel;
    logic [PAGE_WORDS-1:0]           mask;
    logic [PAGE_WORDS-1:0][WORD_W-1:0] bufw;
    word_t                           rd_sh;
    logic [RCNT_W-1:0]               rd_cnt;
    logic                            rd_on;
    logic                            sdo_r;
    logic                            sck_q, cs_q;

    logic  sck_rise, sck_fall, cs_fall, cs_rise;
    word_t shifted;
    cmd_t  cmd_now;

    assign sck_rise = sck & ~sck_q;
    assign sck_fall = ~sck & sck_q;
    assign cs_fall  = ~cs_n & cs_q;
    assign cs_rise  = cs_n & ~cs_q;
    assign shifted  = {sh[WORD_W-2:0], sdi};
    assign cmd_now  = decode_op(shifted[BYTE_W-1:0]);

    assign rd_addr = (state == F_RDOUT) ? addr + addr_t'(1)
                                        : {hi, shifted[BYTE_W-1:0]};

    assign wr_go    = cs_rise && (|mask) && wel && !wp_rst && !busy &&
                      (state == F_DATA || state == F_SKIP);
    assign wr_page  = addr[ADDR_W-1:SLOT_W];
    assign wr_mask  = mask;
    assign wr_words = bufw;

    assign sdo_oe = (state == F_STAT) || (state == F_RDOUT && rd_on);
    assign sdo    = (state == F_STAT) ? ~busy : sdo_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= F_IDLE;
            kind   <= K_NONE;
            hi     <= 1'b0;
            cnt    <= '0;
            sh     <= '0;
            addr   <= '0;
            wel    <= 1'b0;
            mask   <= '0;
            bufw   <= '0;
            rd_sh  <= '0;
            rd_cnt <= '0;
            rd_on  <= 1'b0;
            sdo_r  <= 1'b0;
            sck_q  <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
            if (cs_n) begin
                state <= F_IDLE;
                rd_on <= 1'b0;
                if (cs_rise) mask <= '0;
            end else if (cs_fall) begin
                mask  <= '0;
                cnt   <= '0;
                rd_on <= 1'b0;
                if (!sck)      state <= F_STAT;
                else if (busy) state <= F_SKIP;
                else           state <= F_OPC;
            end else begin
                case (state)
                    F_STAT: begin
                        if (sck_rise && sdi) begin
                            if (busy) state <= F_SKIP;
                            else begin
                                state <= F_OPC;
                                cnt   <= CNT_W'(1);
                                sh    <= word_t'(1);
                            end
                        end
                    end
                    F_OPC: begin
                        if (sck_rise) begin
                            sh  <= shifted;
                            cnt <= cnt + CNT_W'(1);
                            if (cnt == CNT_W'(BYTE_W-1)) begin
                                cnt  <= '0;
                                hi   <= cmd_now.hi;
                                kind <= cmd_now.kind;
                                case (cmd_now.kind)
                                    K_READ, K_WRITE, K_PAGE: state <= F_ADDR;
                                    K_WREN: begin wel <= 1'b1; state <= F_SKIP; end
                                    K_WRDS: begin wel <= 1'b0; state <= F_SKIP; end
                                    default: state <= F_SKIP;
                                endcase
                            end
                        end
                    end
                    F_ADDR: begin
                        if (sck_rise) begin
                            sh  <= shifted;
                            cnt <= cnt + CNT_W'(1);
                            if (cnt == CNT_W'(BYTE_W-1)) begin
                                cnt  <= '0;
                                addr <= rd_addr;
                                if (kind == K_READ) begin
                                    state  <= F_RDOUT;
                                    rd_sh  <= rd_data;
                                    rd_cnt <= '0;
                                end else begin
                                    state <= F_DATA;
                                end
                            end
                        end
                    end
                    F_DATA: begin
                        if (sck_rise) begin
                            sh  <= shifted;
                            cnt <= cnt + CNT_W'(1);
                            if (cnt == CNT_W'(WORD_W-1)) begin
                                cnt <= '0;
                                bufw[addr[SLOT_W-1:0]] <= shifted;
                                mask[addr[SLOT_W-1:0]] <= 1'b1;
                                if (kind == K_PAGE)
                                    addr[SLOT_W-1:0] <= addr[SLOT_W-1:0] + SLOT_W'(1);
                                else
                                    state <= F_SKIP;
                            end
                        end
                    end
                    F_RDOUT: begin
                        if (sck_fall) begin
                            rd_on <= 1'b1;
                            sdo_r <= rd_sh[WORD_W-1];
                            if (rd_cnt == RCNT_W'(WORD_W-1)) begin
                                rd_sh  <= rd_data;
                                addr   <= rd_addr;
                                rd_cnt <= '0;
                            end else begin
                                rd_sh  <= {rd_sh[WORD_W-2:0], 1'b0};
                                rd_cnt <= rd_cnt + RCNT_W'(1);
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R7: data out is never driven once chip select has been high for a cycle
    assert_oe_needs_cs_R7: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> !sdo_oe);

    // R3: the write-enable latch only moves at the end of an op-code
    assert_wel_at_opcode_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(wel) |-> ($past(state) == F_OPC));

    // R6: no frame is decoded while a write cycle runs
    assert_no_decode_busy_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> !(state == F_OPC || state == F_ADDR ||
                   state == F_DATA || state == F_RDOUT));
endmodule

// File: rtl/eep_store.sv
module eep_store
    import eep_pkg::*;
#(
    parameter int BUSY_CYCLES = 64
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              go,
    input  logic [PAGE_W-1:0]                 page,
    input  logic [PAGE_WORDS-1:0]             mask,
    input  logic [PAGE_WORDS-1:0][WORD_W-1:0] words,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [WORD_W-1:0]                 rd_data,
    output logic                              busy
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    word_t                             mem [DEPTH];
    logic [CNT_W-1:0]                  cnt;
    logic [PAGE_W-1:0]                 pg_l;
    logic [PAGE_WORDS-1:0]             msk_l;
    logic [PAGE_WORDS-1:0][WORD_W-1:0] wd_l;
    logic                              start, finish;

    assign start   = go && !busy;
    assign finish  = busy && (cnt == '0);
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            pg_l  <= '0;
            msk_l <= '0;
            wd_l  <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt   <= CNT_W'(BUSY_CYCLES - 1);
            pg_l  <= page;
            msk_l <= mask;
            wd_l  <= words;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - CNT_W'(1);
        end
    end

    // erase phase on entry, program phase on the last busy cycle
    always_ff @(posedge clk) begin
        if (!rst) begin
            for (int i = 0; i < PAGE_WORDS; i++) begin
                if (start && mask[i])
                    mem[{page, SLOT_W'(i)}] <= '1;
                else if (finish && msk_l[i])
                    mem[{pg_l, SLOT_W'(i)}] <= wd_l[i];
            end
        end
    end

    // R5: a write cycle only begins on a commit request
    assert_busy_from_go_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(go));

    // R5: the busy counter stays inside its window
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (int'(cnt) < BUSY_CYCLES));
endmodule

// File: rtl/eep_slave.sv
module eep_slave
    import eep_pkg::*;
#(
    parameter int BUSY_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic sdi,
    input  logic wp_rst,
    output logic sdo,
    output logic sdo_oe,
    output logic ready
);
    logic                              busy;
    logic                              wr_go;
    logic [PAGE_W-1:0]                 wr_page;
    logic [PAGE_WORDS-1:0]             wr_mask;
    logic [PAGE_WORDS-1:0][WORD_W-1:0] wr_words;
    logic [ADDR_W-1:0]                 rd_addr;
    logic [WORD_W-1:0]                 rd_data;

    eep_frame u_frame (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .sck      (sck),
        .sdi      (sdi),
        .wp_rst   (wp_rst),
        .busy     (busy),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe),
        .wr_go    (wr_go),
        .wr_page  (wr_page),
        .wr_mask  (wr_mask),
        .wr_words (wr_words)
    );

    eep_store #(.BUSY_CYCLES(BUSY_CYCLES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .go      (wr_go),
        .page    (wr_page),
        .mask    (wr_mask),
        .words   (wr_words),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .busy    (busy)
    );

    assign ready = ~busy;
endmodule

// File: tb/eep_slave_test.sv
module eep_slave_test;
    localparam int BUSY = 150;
    localparam int H    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b1, sdi = 1'b0, wp_rst = 1'b0;
    logic sdo, sdo_oe, ready;

    eep_slave #(.BUSY_CYCLES(BUSY)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .wp_rst(wp_rst), .sdo(sdo), .sdo_oe(sdo_oe), .ready(ready)
    );

    always #2.5 clk = ~clk;

    int vec = 0, bad = 0, mb = 0;
    bit start_req = 0, done = 0, wel_m = 0;
    logic [15:0] mem_m [512];

    task automatic chk(bit ok, string req, int act, int exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    endtask

    // reference busy window (R5): starts on the first edge after commit
    always @(posedge clk) begin
        if (rst) mb = 0;
        else begin
            if (mb > 0) mb--;
            if (start_req) begin mb = BUSY; start_req = 0; end
        end
    end

    always @(negedge clk)
        if (!rst && !done) chk(ready == (mb == 0), "R5 ready", ready, mb == 0);

    task automatic tick(int n); repeat (n) @(negedge clk); endtask
    task automatic bitout(bit b); sck = 0; sdi = b; tick(H); sck = 1; tick(H); endtask
    task automatic byteout(logic [7:0] v); for (int i = 7; i >= 0; i--) bitout(v[i]); endtask
    task automatic wordout(logic [15:0] v); for (int i = 15; i >= 0; i--) bitout(v[i]); endtask
    task automatic open_frame(); sck = 1; tick(H); cs_n = 0; tick(H); endtask
    task automatic close_frame(bit commit); tick(H); cs_n = 1; start_req = commit; tick(H); endtask
    task automatic wait_idle(); while (mb != 0) tick(1); tick(2); endtask

    task automatic short_cmd(logic [7:0] op); open_frame(); byteout(op); close_frame(0); endtask

    task automatic do_write(logic [8:0] a, logic [15:0] w, bit wp);
        bit commit;
        wp_rst = wp;
        open_frame(); byteout({7'b1010_000, a[8]}); byteout(a[7:0]); wordout(w);
        commit = wel_m && !wp;
        if (commit) mem_m[a] = w;
        close_frame(commit);
        wp_rst = 0;
        wait_idle();
    endtask

    task automatic page_write(logic [8:0] a, int n, logic [15:0] base);
        logic [15:0] w;
        logic [2:0]  s;
        open_frame(); byteout({7'b1011_000, a[8]}); byteout(a[7:0]);
        for (int i = 0; i < n; i++) begin
            w = base + 16'(i * 16'h0111);
            s = a[2:0] + 3'(i);
            wordout(w);
            if (wel_m) mem_m[{a[8:3], s}] = w;
        end
        close_frame(wel_m);
        wait_idle();
    endtask

    task automatic read_words(logic [8:0] a, int n, string req);
        logic [15:0] got;
        logic [8:0]  ra;
        bit oe_ok;
        open_frame(); byteout({7'b1000_000, a[8]}); byteout(a[7:0]);
        for (int k = 0; k < n; k++) begin
            oe_ok = 1;
            for (int j = 15; j >= 0; j--) begin
                sck = 0; tick(H);
                got[j] = sdo;
                if (sdo_oe !== 1'b1) oe_ok = 0;
                sck = 1; tick(H);
            end
            ra = a + 9'(k);
            chk(got == mem_m[ra], req, got, mem_m[ra]);
            chk(oe_ok, "R2 sdo_oe during read", oe_ok, 1);
        end
        close_frame(0);
    endtask

    task automatic status_probe(string req);
        sck = 0; tick(H); cs_n = 0; tick(H);
        chk(sdo_oe == 1, {req, " status oe"}, sdo_oe, 1);
        chk(sdo == (mb == 0), {req, " status level"}, sdo, mb == 0);
        sdi = 0; sck = 1; tick(H); sck = 0; tick(H);
        chk(sdo_oe == 1, "R7 zero bit keeps status", sdo_oe, 1);
        sdi = 1; sck = 1; tick(H);
        chk(sdo_oe == 0, "R7 one bit ends status", sdo_oe, 0);
        cs_n = 1; tick(H); sdi = 0;
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem_m[i] = 16'h0;
        tick(4);
        rst = 0;
        tick(2);
        chk(ready == 1, "R1 ready after reset", ready, 1);
        chk(sdo_oe == 0, "R1 oe after reset", sdo_oe, 0);
        // R1/R3: latch clear after reset, so this write must not happen
        do_write(9'h005, 16'hDEAD, 0);
        short_cmd(8'b1001_1000); wel_m = 1;                 // R3 WREN
        do_write(9'h005, 16'h1234, 0);
        read_words(9'h005, 1, "R2 read word");
        do_write(9'h105, 16'hBEEF, 0);
        read_words(9'h105, 1, "R11 upper half");
        read_words(9'h005, 1, "R11 lower half intact");
        short_cmd(8'b1001_0000); wel_m = 0;                 // R3 WRDS
        do_write(9'h005, 16'hFFFF, 0);
        read_words(9'h005, 1, "R3 write blocked by WRDS");
        short_cmd(8'b1001_1000); wel_m = 1;
        do_write(9'h005, 16'h0000, 1);
        read_words(9'h005, 1, "R4 write blocked by wp_rst");
        // R9: abort after 10 data bits
        open_frame(); byteout(8'b1010_0000); byteout(8'h05);
        for (int i = 0; i < 10; i++) bitout(1'b0);
        close_frame(0); wait_idle();
        read_words(9'h005, 1, "R9 aborted frame");
        // R8: page write wrapping inside the page
        page_write(9'h0F6, 4, 16'h3000);
        read_words(9'h0F6, 2, "R8 page words 6..7");
        read_words(9'h0F0, 2, "R8 page wrap to 0..1");
        // R10: streaming and address wrap
        do_write(9'h000, 16'h0F0F, 0);
        do_write(9'h1FF, 16'hA5A5, 0);
        read_words(9'h1FF, 2, "R10 wrap 511 to 0");
        read_words(9'h0F6, 2, "R10 ascending stream");
        // R6/R7: status and ignored frame during a write cycle
        wp_rst = 0;
        open_frame(); byteout(8'b1010_0000); byteout(8'h10); wordout(16'h5555);
        mem_m[9'h010] = 16'h5555;
        close_frame(1);
        status_probe("R7 busy");
        open_frame();
        byteout(8'b1001_0000);                              // WRDS while busy
        chk(sdo_oe == 0, "R6 no output while busy", sdo_oe, 0);
        close_frame(0);
        wait_idle();
        status_probe("R7 ready");
        do_write(9'h011, 16'h6666, 0);                      // R6: latch still set
        read_words(9'h010, 2, "R6 WRDS ignored during busy");
        // R7: status ended by chip select rise
        sck = 0; tick(H); cs_n = 0; tick(H);
        chk(sdo_oe == 1, "R7 status entry", sdo_oe, 1);
        cs_n = 1; tick(3);
        chk(sdo_oe == 0, "R7 cs rise ends status", sdo_oe, 0);
        tick(4);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
        end
    end
endmodule